// File: doc/BRIEF.md
# Mirrored-Readback Register Bank

This block gives a microcontroller access to a bank of byte-wide configuration registers and a small group of status words over a plain strobe bus. The bus has an address, a chip select, separate write and read strobes, and separate write-data and read-data lines. Each configuration register drives its eight bits straight into the surrounding logic, so that logic needs no addressing to use them. Every host write to a configuration register also updates a copy of that byte in a shadow memory. Host reads are always answered from that memory, so the block needs no wide readback multiplexer over the physical registers.

Status words come from the surrounding logic. Each status word has its own update strobe and a fixed slot in the shadow memory, and it reaches that slot through a second write path. The host reads status words from the same memory as the configuration bytes. The host strobes are not tied to the block clock. The block passes them through a synchroniser and acts on each rising edge once.

Top module: `regbank_shadow`

## Requirements
- R1: After reset, every bit of `ctrl_bits` is 0, `host_rdata` is 0x00, and every shadow location reads back as 0x00.
- R2: A host write to an address A below NUM_CTRL (default 48) sets `ctrl_bits[8*A +: 8]` to the write data and leaves every other control byte unchanged. Control outputs change only on such a write.
- R3: A host read of a control address A returns the byte most recently written to A, taken from the shadow copy.
- R4: A pulse on `stat_upd[k]` stores `stat_data[8*k +: 8]` at shadow address NUM_CTRL+k (48+k by default). A later host read of that address returns the stored byte.
- R5: A host write to a status address (NUM_CTRL to NUM_CTRL+NUM_STAT-1) changes neither the stored status byte nor any control output.
- R6: When a host write to a status address and a status update of that same word are acted on in the same clock cycle, the status value is stored.
- R7: A read of an address at or above NUM_CTRL+NUM_STAT (56 by default) returns 0x00. A write to such an address changes no control output.
- R8: `host_rdata` is registered. It changes only in the cycle after a read is acted on, and it holds that value until the next read. A read acted on in the same cycle as a status update of the addressed word returns the value stored before that update.
- R9: The strobes pass through a synchroniser. Each write or read is acted on once, at the rising edge of the strobe while `host_cs` is high. Holding a strobe high does not repeat the access, and a strobe without chip select is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | ADDR_W (6) | Host register address, held stable while a strobe is high |
| host_cs | input | 1 | Host chip select, active high |
| host_wr | input | 1 | Host write strobe, active high, asynchronous |
| host_rd | input | 1 | Host read strobe, active high, asynchronous |
| host_wdata | input | 8 | Host write data, held stable while the write strobe is high |
| host_rdata | output | 8 | Registered read data |
| ctrl_bits | output | NUM_CTRL*8 (384) | All control registers in parallel; byte A is bits 8*A+7 down to 8*A |
| stat_upd | input | NUM_STAT (8) | Per-word status update strobe, one cycle per update |
| stat_data | input | NUM_STAT*8 (64) | Status words; word k is bits 8*k+7 down to 8*k |

## Verification
The host path and the status path meet at the shadow memory, and two cases of this are provoked. In the first, a host write to status word k and a `stat_upd[k]` pulse take effect in the same cycle. In the second, a host read of status word k takes effect in the same cycle as an update of that word. The bench counts the synchroniser stages to place the status pulse exactly on the clock edge where the delayed strobe edge is acted on. It then judges both results by reading back: the first case must leave the status value in memory, and the second must return the old byte and then the new byte on the next read. Random mixes of writes, reads and status pulses over the whole address space are then compared against a byte model kept in the bench.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/regbank_edge_sync.sv
// Brings an asynchronous level into the clock domain and flags its rising edge for one cycle.
module regbank_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_lvl,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_lvl};
        s_d.last  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.chain[STAGES-1] & ~s_q.last;
endmodule

// File: rtl/regbank_ctrl_file.sv
// Physical control registers, every bit presented in parallel.
module regbank_ctrl_file
    import regbank_pkg::*;
#(
    parameter int NUM_CTRL = 48,
    parameter int ADDR_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  byte_t                      wdata,
    output logic [NUM_CTRL*BYTE_W-1:0] bits
);
    typedef struct packed {
        logic [NUM_CTRL-1:0][BYTE_W-1:0] regs;
    } ctrl_st_t;

    ctrl_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (we && (int'(addr) == i)) c_d.regs[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign bits = c_q.regs;
endmodule

// File: rtl/regbank_shadow_ram.sv
// Shadow copy: host port for control slots, hardwired status port per status slot.
module regbank_shadow_ram
    import regbank_pkg::*;
#(
    parameter int NUM_CTRL = 48,
    parameter int NUM_STAT = 8,
    parameter int ADDR_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_we,
    input  logic [ADDR_W-1:0]          host_addr,
    input  byte_t                      host_data,
    input  logic [NUM_STAT-1:0]        st_upd,
    input  logic [NUM_STAT*BYTE_W-1:0] st_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output byte_t                      rd_data
);
    localparam int DEPTH = NUM_CTRL + NUM_STAT;

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
    } ram_st_t;

    ram_st_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        // host port first
        for (int i = 0; i < DEPTH; i++) begin
            if (host_we && (int'(host_addr) == i)) m_d.mem[i] = host_data;
        end
        // status port last, so it takes the word on a collision
        for (int k = 0; k < NUM_STAT; k++) begin
            if (st_upd[k]) m_d.mem[NUM_CTRL+k] = st_data[k*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(rd_addr) == i) rd_data = m_q.mem[i];
        end
    end
endmodule

// File: rtl/regbank_shadow.sv
module regbank_shadow
    import regbank_pkg::*;
#(
    parameter int NUM_CTRL    = 48,
    parameter int NUM_STAT    = 8,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic                       host_cs,
    input  logic                       host_wr,
    input  logic                       host_rd,
    input  logic [BYTE_W-1:0]          host_wdata,
    output logic [BYTE_W-1:0]          host_rdata,
    output logic [NUM_CTRL*BYTE_W-1:0] ctrl_bits,
    input  logic [NUM_STAT-1:0]        stat_upd,
    input  logic [NUM_STAT*BYTE_W-1:0] stat_data
);
    localparam int MAP_END = NUM_CTRL + NUM_STAT;

    typedef struct packed {
        byte_t rdata;
    } top_st_t;

    top_st_t t_d, t_q;

    logic  wr_fire;
    logic  rd_fire;
    logic  ctrl_hit;
    logic  mapped;
    byte_t ram_rd;

    regbank_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_lvl (host_cs & host_wr),
        .rise      (wr_fire)
    );

    regbank_edge_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_lvl (host_cs & host_rd),
        .rise      (rd_fire)
    );

    assign ctrl_hit = int'(host_addr) < NUM_CTRL;
    assign mapped   = int'(host_addr) < MAP_END;

    regbank_ctrl_file #(.NUM_CTRL(NUM_CTRL), .ADDR_W(ADDR_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_fire & ctrl_hit),
        .addr  (host_addr),
        .wdata (host_wdata),
        .bits  (ctrl_bits)
    );

    regbank_shadow_ram #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT), .ADDR_W(ADDR_W)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (wr_fire & ctrl_hit),
        .host_addr (host_addr),
        .host_data (host_wdata),
        .st_upd    (stat_upd),
        .st_data   (stat_data),
        .rd_addr   (host_addr),
        .rd_data   (ram_rd)
    );

    always_comb begin
        t_d = t_q;
        if (rd_fire) t_d.rdata = mapped ? ram_rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign host_rdata = t_q.rdata;
endmodule

// File: rtl/regbank_shadow_chk.sv
module regbank_shadow_chk #(
    parameter int NUM_CTRL = 48,
    parameter int NUM_STAT = 8,
    parameter int ADDR_W   = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_fire,
    input logic                  rd_fire,
    input logic [ADDR_W-1:0]     host_addr,
    input logic [7:0]            host_wdata,
    input logic [7:0]            host_rdata,
    input logic [NUM_CTRL*8-1:0] ctrl_bits
);
    localparam int MAP_END = NUM_CTRL + NUM_STAT;

    logic              seen_q;
    logic [ADDR_W-1:0] seen_addr_q;
    logic [7:0]        seen_data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            seen_addr_q <= '0;
            seen_data_q <= '0;
        end else if (wr_fire && int'(host_addr) < NUM_CTRL) begin
            seen_q      <= 1'b1;
            seen_addr_q <= host_addr;
            seen_data_q <= host_wdata;
        end
    end

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ctrl_bits[int'(seen_addr_q)*8 +: 8] == seen_data_q);

    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(ctrl_bits));

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && int'(host_addr) >= MAP_END) |=> host_rdata == 8'h00);

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(host_rdata));

    assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);

    assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> !rd_fire);
endmodule

bind regbank_shadow regbank_shadow_chk #(
    .NUM_CTRL (NUM_CTRL),
    .NUM_STAT (NUM_STAT),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .rd_fire    (rd_fire),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ctrl_bits  (ctrl_bits)
);

// File: tb/regbank_shadow_test.sv
`timescale 1ns/1ps
module regbank_shadow_test;
    localparam int NC = 48;
    localparam int NS = 8;
    localparam int AW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  host_addr = '0;
    logic           host_cs = 1'b0;
    logic           host_wr = 1'b0;
    logic           host_rd = 1'b0;
    logic [7:0]     host_wdata = '0;
    logic [7:0]     host_rdata;
    logic [NC*8-1:0] ctrl_bits;
    logic [NS-1:0]  stat_upd = '0;
    logic [NS*8-1:0] stat_data = '0;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_ctrl [NC];
    logic [7:0] exp_stat [NS];

    always #2 clk = ~clk;

    regbank_shadow uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_cs(host_cs),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ctrl_bits(ctrl_bits),
        .stat_upd(stat_upd), .stat_data(stat_data)
    );

    function automatic logic [7:0] model_read(int a);
        if (a < NC)      return exp_ctrl[a];
        if (a < NC + NS) return exp_stat[a-NC];
        return 8'h00;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_ctrl(string req);
        int bad = -1;
        tests++;
        for (int i = 0; i < NC; i++)
            if (bad < 0 && ctrl_bits[i*8 +: 8] !== exp_ctrl[i]) bad = i;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: ctrl byte %0d got %02h expected %02h",
                     req, bad, ctrl_bits[bad*8 +: 8], exp_ctrl[bad]);
        end
    endtask

    task automatic host_write(int a, logic [7:0] d, bit cs);
        @(negedge clk);
        host_addr = AW'(a); host_wdata = d; host_cs = cs; host_wr = 1'b1;
        repeat (4) @(negedge clk);
        host_wr = 1'b0; host_cs = 1'b0;
        repeat (2) @(negedge clk);
        if (cs && a < NC) exp_ctrl[a] = d;
    endtask

    task automatic host_read(int a, output logic [7:0] r);
        @(negedge clk);
        host_addr = AW'(a); host_cs = 1'b1; host_rd = 1'b1;
        repeat (4) @(negedge clk);
        r = host_rdata;
        host_rd = 1'b0; host_cs = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic stat_pulse(int k, logic [7:0] v);
        @(negedge clk);
        stat_upd[k] = 1'b1; stat_data[k*8 +: 8] = v;
        @(negedge clk);
        stat_upd = '0;
        exp_stat[k] = v;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        logic [7:0] old;
        for (int i = 0; i < NC; i++) exp_ctrl[i] = 8'h00;
        for (int k = 0; k < NS; k++) exp_stat[k] = 8'h00;
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk_ctrl("R1 ctrl after reset");
        chk("R1 rdata after reset", host_rdata, 8'h00);
        host_read(0, r);  chk("R1 shadow ctrl", r, 8'h00);
        host_read(NC+3, r); chk("R1 shadow status", r, 8'h00);

        // R2 / R3 directed writes at both ends of the control range
        host_write(0, 8'h5a, 1'b1);
        host_write(NC-1, 8'hc3, 1'b1);
        chk_ctrl("R2 edge writes");
        host_read(0, r);    chk("R3 read addr 0", r, 8'h5a);
        host_read(NC-1, r); chk("R3 read last ctrl", r, 8'hc3);

        // R4 status readback
        stat_pulse(0, 8'h11);
        stat_pulse(NS-1, 8'hee);
        host_read(NC, r);      chk("R4 status 0", r, 8'h11);
        host_read(NC+NS-1, r); chk("R4 last status", r, 8'hee);

        // R5 host write to status ignored
        host_write(NC+NS-1, 8'h00, 1'b1);
        chk_ctrl("R5 ctrl untouched");
        host_read(NC+NS-1, r); chk("R5 status kept", r, 8'hee);

        // R7 unmapped
        host_write(NC+NS, 8'h77, 1'b1);
        host_write(63, 8'h99, 1'b1);
        chk_ctrl("R7 unmapped write");
        host_read(NC+NS, r); chk("R7 unmapped read", r, 8'h00);
        host_read(63, r);    chk("R7 top read", r, 8'h00);

        // R9 chip select low ignored
        host_write(5, 8'hab, 1'b0);
        chk_ctrl("R9 no cs");

        // R9 long strobe acts once, data changed after the edge is taken
        @(negedge clk);
        host_addr = AW'(7); host_wdata = 8'h3c; host_cs = 1'b1; host_wr = 1'b1;
        repeat (4) @(negedge clk);
        host_wdata = 8'hff;
        repeat (8) @(negedge clk);
        host_wr = 1'b0; host_cs = 1'b0;
        repeat (2) @(negedge clk);
        exp_ctrl[7] = 8'h3c;
        chk_ctrl("R9 single action");

        // R6 host write to status word and status update in the same cycle
        @(negedge clk);
        host_addr = AW'(NC+2); host_wdata = 8'haa; host_cs = 1'b1; host_wr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        stat_upd[2] = 1'b1; stat_data[2*8 +: 8] = 8'h42;
        @(negedge clk);
        stat_upd = '0;
        @(negedge clk);
        host_wr = 1'b0; host_cs = 1'b0;
        repeat (2) @(negedge clk);
        exp_stat[2] = 8'h42;
        host_read(NC+2, r); chk("R6 status wins", r, 8'h42);

        // R8 read and status update of the same word in the same cycle
        old = exp_stat[4];
        @(negedge clk);
        host_addr = AW'(NC+4); host_cs = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        @(negedge clk);
        stat_upd[4] = 1'b1; stat_data[4*8 +: 8] = 8'h6d;
        @(negedge clk);
        stat_upd = '0;
        chk("R8 same-cycle read old", host_rdata, old);
        @(negedge clk);
        host_rd = 1'b0; host_cs = 1'b0;
        repeat (2) @(negedge clk);
        exp_stat[4] = 8'h6d;
        chk("R8 rdata held", host_rdata, old);
        host_read(NC+4, r); chk("R8 next read new", r, 8'h6d);

        // random mix
        for (int n = 0; n < 300; n++) begin
            int op = $urandom_range(0, 2);
            int a  = $urandom_range(0, 63);
            logic [7:0] d = 8'($urandom);
            if (op == 0) begin
                host_write(a, d, 1'b1);
                chk_ctrl("R2 random write");
            end else if (op == 1) begin
                host_read(a, r);
                chk(a < NC ? "R3 random read" : (a < NC+NS ? "R4 random read" : "R7 random read"),
                    r, model_read(a));
            end else begin
                stat_pulse($urandom_range(0, NS-1), d);
            end
        end

        finish_run();
    end
endmodule